// File: doc/BRIEF.md
# Four-Lane Receive Synchronization Controller

This block decides, lane by lane, whether a four-lane serial receiver is in step with the incoming character stream. It watches each lane's clock-recovery lock flag and the per-character results from the lane's line decoder: a valid strobe, an error flag and a comma flag. From these it reports, for every lane, whether the lane has no synchronization, is acquiring it, or holds it. A global flag is raised once all lanes hold sync, and an align enable is raised so a downstream deskew stage knows a sync pattern is expected.

Nothing can start until every lane's recovery lock has held without a break for a long qualification interval, 32000 cycles by default. Once qualified and enabled, a lane waits for four error-free commas in a row. A locked lane falls back when its errors come in a run or too densely inside a block of sixteen characters. A loss of recovery lock on any lane, a low channel-lock enable or the active-low reset drops every lane to no-sync at once.

Top module: `lane_sync_ctrl`

## Requirements
- R1: A lane leaves no-sync (going to acquiring on the next clock edge) only when the channel-lock enable is high and every lane's recovery lock has been high without a break for QUAL_CYCLES consecutive clock edges.
- R2: When any lane's recovery lock is low at a clock edge, every lane is in no-sync after that edge and the qualification interval of R1 starts again from zero.
- R3: While the channel-lock enable is low, every lane is in no-sync after each clock edge and characters have no effect; the qualification count is kept, so lanes go to acquiring on the first edge after the enable returns.
- R4: While the active-low reset is low, every lane reads no-sync and the lock flag is low at once, and the qualification count is cleared.
- R5: An acquiring lane becomes locked on the fourth consecutive valid character that has the comma flag set and the error flag clear; any other valid character restarts that count.
- R6: A locked lane goes to no-sync on its fourth consecutive valid character with the error flag set; a valid error-free character clears the run.
- R7: A locked lane goes to no-sync on the ninth errored character inside a block of sixteen valid characters; blocks are counted from entry into the locked state and the error tally restarts after every sixteenth character.
- R8: The lock-detected output is high exactly when all four lanes are locked; the align enable is high whenever at least one lane is acquiring.
- R9: Lane i's status sits at bits [2i+1:2i] of the status bus, coded 2'b00 no-sync, 2'b01 acquiring, 2'b10 locked (2'b11 never appears); error faults of R6 and R7 affect only the lane that saw them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, forces no-sync |
| cdr_lock | input | LANES | Per-lane clock-recovery lock |
| chan_lock_en | input | 1 | Global enable for channel locking |
| chr_valid | input | LANES | Per-lane decoded-character strobe |
| chr_err | input | LANES | Decoder error for the strobed character |
| chr_comma | input | LANES | Strobed character is a comma |
| lane_state | output | 2*LANES | Per-lane sync status, 2 bits per lane |
| chan_locked | output | 1 | All lanes locked |
| deskew_align | output | 1 | Some lane is acquiring; deskew should align |

## Verification
Acquisition is driven with plain comma runs on all lanes, and with a comma run broken by a data character on one lane, which tells a consecutive count from a plain total. Errors are sent as an isolated run interrupted by a clean character, to separate the run test from a cumulative count, and as a repeating two-errors-one-clean pattern that only the density test can catch. A second lane carries a pattern that holds more than eight errors across a block boundary but no more than eight inside any aligned block, which tells an aligned window from a sliding one. Enable, lock-drop and reset are each applied from the locked state and followed through the qualification interval, showing which of them restart the timer.

// File: rtl/lsync_pkg.sv
package lsync_pkg;
    typedef enum logic [1:0] {
        LS_NOSYNC = 2'b00,
        LS_ACQ    = 2'b01,
        LS_LOCKED = 2'b10
    } lane_st_e;
endpackage

// File: rtl/lsync_qual_timer.sv
// Qualification timer: counts edges with all recovery locks high, saturating.
module lsync_qual_timer #(
    parameter int QUAL_W      = 15,
    parameter int QUAL_CYCLES = 32000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_locked,
    output logic qualified
);
    localparam logic [QUAL_W-1:0] LIMIT = QUAL_W'(QUAL_CYCLES);

    typedef struct packed {
        logic [QUAL_W-1:0] cnt;
    } timer_reg_t;

    timer_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!all_locked) begin
            r_d.cnt = '0;
        end else if (r_q.cnt != LIMIT) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign qualified = (r_q.cnt == LIMIT);
endmodule

// File: rtl/lsync_lane.sv
// Per-lane sync state machine with comma acquisition and two error tests.
module lsync_lane
    import lsync_pkg::*;
#(
    parameter int COMMA_RUN   = 4,
    parameter int ERR_RUN     = 4,
    parameter int WIN_LEN     = 16,
    parameter int WIN_MAX_ERR = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     force_nosync,
    input  logic     may_start,
    input  logic     chr_valid,
    input  logic     chr_err,
    input  logic     chr_comma,
    output lane_st_e state
);
    localparam int CR_W = $clog2(COMMA_RUN + 1);
    localparam int ER_W = $clog2(ERR_RUN + 1);
    localparam int WP_W = $clog2(WIN_LEN);
    localparam int WE_W = $clog2(WIN_LEN + 1);

    typedef struct packed {
        lane_st_e        st;
        logic [CR_W-1:0] comma_run;
        logic [ER_W-1:0] err_run;
        logic [WP_W-1:0] win_pos;
        logic [WE_W-1:0] win_err;
    } lane_reg_t;

    localparam lane_reg_t CLR = '0;

    lane_reg_t       r_d, r_q;
    logic            fault;
    logic [WE_W-1:0] win_err_n;

    always_comb begin
        r_d       = r_q;
        fault     = 1'b0;
        win_err_n = r_q.win_err + WE_W'(chr_err);
        case (r_q.st)
            LS_NOSYNC: begin
                r_d = CLR;
                if (may_start) r_d.st = LS_ACQ;
            end
            LS_ACQ: begin
                if (chr_valid) begin
                    if (chr_comma && !chr_err) begin
                        if (r_q.comma_run == CR_W'(COMMA_RUN - 1)) begin
                            r_d    = CLR;
                            r_d.st = LS_LOCKED;
                        end else begin
                            r_d.comma_run = r_q.comma_run + 1'b1;
                        end
                    end else begin
                        r_d.comma_run = '0;
                    end
                end
            end
            LS_LOCKED: begin
                if (chr_valid) begin
                    if (chr_err) begin
                        if (r_q.err_run == ER_W'(ERR_RUN - 1)) fault = 1'b1;
                        else r_d.err_run = r_q.err_run + 1'b1;
                    end else begin
                        r_d.err_run = '0;
                    end
                    if (win_err_n > WE_W'(WIN_MAX_ERR)) fault = 1'b1;
                    if (r_q.win_pos == WP_W'(WIN_LEN - 1)) begin
                        r_d.win_pos = '0;
                        r_d.win_err = '0;
                    end else begin
                        r_d.win_pos = r_q.win_pos + 1'b1;
                        r_d.win_err = win_err_n;
                    end
                end
            end
            default: r_d = CLR;
        endcase
        if (fault || force_nosync) r_d = CLR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CLR;
        else        r_q <= r_d;
    end

    assign state = r_q.st;
endmodule

// File: rtl/lane_sync_ctrl.sv
// Top: qualification timer plus one state machine per lane.
module lane_sync_ctrl
    import lsync_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int QUAL_W      = 15,
    parameter int QUAL_CYCLES = 32000,
    parameter int COMMA_RUN   = 4,
    parameter int ERR_RUN     = 4,
    parameter int WIN_LEN     = 16,
    parameter int WIN_MAX_ERR = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   cdr_lock,
    input  logic               chan_lock_en,
    input  logic [LANES-1:0]   chr_valid,
    input  logic [LANES-1:0]   chr_err,
    input  logic [LANES-1:0]   chr_comma,
    output logic [2*LANES-1:0] lane_state,
    output logic               chan_locked,
    output logic               deskew_align
);
    logic             all_locked;
    logic             qualified;
    logic             force_nosync;
    logic             may_start;
    logic [LANES-1:0] is_locked;
    logic [LANES-1:0] is_acq;

    assign all_locked   = &cdr_lock;
    assign force_nosync = !chan_lock_en || !all_locked;
    assign may_start    = qualified && chan_lock_en;

    lsync_qual_timer #(
        .QUAL_W     (QUAL_W),
        .QUAL_CYCLES(QUAL_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .all_locked(all_locked),
        .qualified (qualified)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_st_e st;
        lsync_lane #(
            .COMMA_RUN  (COMMA_RUN),
            .ERR_RUN    (ERR_RUN),
            .WIN_LEN    (WIN_LEN),
            .WIN_MAX_ERR(WIN_MAX_ERR)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .force_nosync(force_nosync),
            .may_start   (may_start),
            .chr_valid   (chr_valid[g]),
            .chr_err     (chr_err[g]),
            .chr_comma   (chr_comma[g]),
            .state       (st)
        );
        assign lane_state[2*g +: 2] = st;
        assign is_locked[g]         = (st == LS_LOCKED);
        assign is_acq[g]            = (st == LS_ACQ);
    end

    assign chan_locked  = &is_locked;
    assign deskew_align = |is_acq;
endmodule

// File: rtl/lane_sync_ctrl_chk.sv
// Property checker bound to the top.
module lane_sync_ctrl_chk #(
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LANES-1:0]   cdr_lock,
    input logic               chan_lock_en,
    input logic [LANES-1:0]   chr_valid,
    input logic [LANES-1:0]   chr_err,
    input logic [LANES-1:0]   chr_comma,
    input logic [2*LANES-1:0] lane_state,
    input logic               chan_locked,
    input logic               deskew_align
);
    AST_LOCKDROP_NOSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cdr_lock) |=> (lane_state == '0));  // R2

    AST_ENABLE_LOW_NOSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_lock_en |=> (lane_state == '0));  // R3

    AST_ALIGN_EXCLUDES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        deskew_align |-> !chan_locked);  // R8

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            lane_state[2*g +: 2] != 2'b11);  // R9

        AST_NO_SKIP_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_state[2*g +: 2] == 2'b00) |=> (lane_state[2*g +: 2] != 2'b10));  // R5

        AST_START_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_state[2*g +: 2] == 2'b00) ##1 (lane_state[2*g +: 2] == 2'b01)
            |-> $past(chan_lock_en && (&cdr_lock)));  // R1

        AST_LOCK_NEEDS_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_state[2*g +: 2] == 2'b01) ##1 (lane_state[2*g +: 2] == 2'b10)
            |-> $past(chr_valid[g] && chr_comma[g] && !chr_err[g]));  // R5

        AST_FAULT_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_state[2*g +: 2] == 2'b10) ##1 (lane_state[2*g +: 2] == 2'b00)
            |-> $past(!chan_lock_en || !(&cdr_lock) || (chr_valid[g] && chr_err[g])));  // R6
    end
endmodule

bind lane_sync_ctrl lane_sync_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cdr_lock    (cdr_lock),
    .chan_lock_en(chan_lock_en),
    .chr_valid   (chr_valid),
    .chr_err     (chr_err),
    .chr_comma   (chr_comma),
    .lane_state  (lane_state),
    .chan_locked (chan_locked),
    .deskew_align(deskew_align)
);

// File: tb/lane_sync_ctrl_test.sv
module lane_sync_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL       = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cdr_lock = 4'b0000;
    logic       chan_lock_en = 1'b0;
    logic [3:0] chr_valid = '0;
    logic [3:0] chr_err = '0;
    logic [3:0] chr_comma = '0;
    logic [7:0] lane_state;
    logic       chan_locked;
    logic       deskew_align;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_sync_ctrl #(.QUAL_CYCLES(QUAL)) uut (
        .clk(clk), .rst_n(rst_n), .cdr_lock(cdr_lock), .chan_lock_en(chan_lock_en),
        .chr_valid(chr_valid), .chr_err(chr_err), .chr_comma(chr_comma),
        .lane_state(lane_state), .chan_locked(chan_locked), .deskew_align(deskew_align)
    );

    // Status codes (R9): 00 no-sync, 01 acquiring, 10 locked, lane i at [2i+1:2i]
    localparam logic [7:0] ALL_N = 8'b00000000;
    localparam logic [7:0] ALL_A = 8'b01010101;
    localparam logic [7:0] ALL_L = 8'b10101010;

    typedef struct packed {
        logic [3:0] v;
        logic [3:0] e;
        logic [3:0] c;
        logic [7:0] st;
        logic       ch;
        logic       dk;
    } vec_t;

    // Applied with all locks high and enable high, starting from all lanes acquiring.
    localparam vec_t TBL [20] = '{
        '{4'b1111, 4'b0000, 4'b1111, 8'b01010101, 1'b0, 1'b1},  // R5 comma 1
        '{4'b1111, 4'b0000, 4'b1111, 8'b01010101, 1'b0, 1'b1},  // R5 comma 2
        '{4'b1111, 4'b0000, 4'b1111, 8'b01010101, 1'b0, 1'b1},  // R5 comma 3
        '{4'b1111, 4'b0000, 4'b1111, 8'b10101010, 1'b1, 1'b0},  // R5 R8 locked
        '{4'b0001, 4'b0001, 4'b0000, 8'b10101010, 1'b1, 1'b0},  // R6 err 1
        '{4'b0001, 4'b0001, 4'b0000, 8'b10101010, 1'b1, 1'b0},  // R6 err 2
        '{4'b0001, 4'b0001, 4'b0000, 8'b10101010, 1'b1, 1'b0},  // R6 err 3
        '{4'b0001, 4'b0000, 4'b0000, 8'b10101010, 1'b1, 1'b0},  // R6 clean clears run
        '{4'b0001, 4'b0001, 4'b0000, 8'b10101010, 1'b1, 1'b0},  // R6 err 1
        '{4'b0001, 4'b0001, 4'b0000, 8'b10101010, 1'b1, 1'b0},  // R6 err 2
        '{4'b0001, 4'b0001, 4'b0000, 8'b10101010, 1'b1, 1'b0},  // R6 err 3
        '{4'b0001, 4'b0001, 4'b0000, 8'b10101000, 1'b0, 1'b0},  // R6 R9 err 4: lane0 only
        '{4'b0000, 4'b0000, 4'b0000, 8'b10101001, 1'b0, 1'b1},  // R1 R8 lane0 acquiring
        '{4'b0001, 4'b0000, 4'b0001, 8'b10101001, 1'b0, 1'b1},  // R5 comma 1
        '{4'b0001, 4'b0000, 4'b0001, 8'b10101001, 1'b0, 1'b1},  // R5 comma 2
        '{4'b0001, 4'b0000, 4'b0000, 8'b10101001, 1'b0, 1'b1},  // R5 data restarts count
        '{4'b0001, 4'b0000, 4'b0001, 8'b10101001, 1'b0, 1'b1},  // R5 comma 1
        '{4'b0001, 4'b0000, 4'b0001, 8'b10101001, 1'b0, 1'b1},  // R5 comma 2
        '{4'b0001, 4'b0000, 4'b0001, 8'b10101001, 1'b0, 1'b1},  // R5 comma 3
        '{4'b0001, 4'b0000, 4'b0001, 8'b10101010, 1'b1, 1'b0}   // R5 comma 4 locks
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance one clock edge, then sample at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        chr_valid = '0; chr_err = '0; chr_comma = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // Reset state
        #(CLK_PERIOD/4);
        check("R4 reset state", lane_state, ALL_N);
        check("R4 reset lock flag", chan_locked, 1'b0);
        check("R8 reset align", deskew_align, 1'b0);

        @(negedge clk);
        cdr_lock = 4'b1111; chan_lock_en = 1'b1; rst_n = 1'b1;
        repeat (QUAL) step();
        check("R1 still no-sync before qualification", lane_state, ALL_N);
        step();
        check("R1 acquiring after qualification", lane_state, ALL_A);
        check("R8 align while acquiring", deskew_align, 1'b1);

        // Vector table
        for (int i = 0; i < 20; i++) begin
            chr_valid = TBL[i].v; chr_err = TBL[i].e; chr_comma = TBL[i].c;
            step();
            check($sformatf("R5/R6 table %0d state", i), lane_state, TBL[i].st);
            check($sformatf("R8 table %0d lock flag", i), chan_locked, TBL[i].ch);
            check($sformatf("R8 table %0d align", i), deskew_align, TBL[i].dk);
        end

        // R7: lane1 two-errors-one-clean, lane2 eight errors per aligned block
        for (int k = 0; k < 20; k++) begin
            logic e1, e2;
            e1 = (k % 3) != 2;
            if (k < 4)       e2 = 1'b0;
            else if (k < 16) e2 = ((k - 4) % 3) != 2;
            else             e2 = (k != 18);
            chr_valid = 4'b0110; chr_comma = '0;
            chr_err = {1'b0, e2, e1, 1'b0};
            step();
            check($sformatf("R7 lane1 char %0d", k), lane_state[3:2],
                  (k < 12) ? 2'b10 : ((k == 12) ? 2'b00 : 2'b01));
            check($sformatf("R7 lane2 aligned block char %0d", k), lane_state[5:4], 2'b10);
        end
        idle();

        // R3: enable low forces no-sync and ignores commas
        chan_lock_en = 1'b0;
        step();
        check("R3 enable low forces no-sync", lane_state, ALL_N);
        chr_valid = 4'b1111; chr_comma = 4'b1111;
        repeat (4) step();
        check("R3 commas ignored while disabled", lane_state, ALL_N);
        idle();
        chan_lock_en = 1'b1;
        step();
        check("R3 timer kept across enable", lane_state, ALL_A);

        // R2: lock drop on one lane
        cdr_lock = 4'b0111;
        step();
        check("R2 lock drop forces no-sync", lane_state, ALL_N);
        cdr_lock = 4'b1111;
        repeat (QUAL) step();
        check("R2 timer restarted after lock drop", lane_state, ALL_N);
        step();
        check("R1 acquiring after requalification", lane_state, ALL_A);

        // Lock all lanes, then reset
        chr_valid = 4'b1111; chr_comma = 4'b1111;
        repeat (4) step();
        check("R8 all locked", chan_locked, 1'b1);
        idle();
        rst_n = 1'b0;
        #1;
        check("R4 reset forces no-sync", lane_state, ALL_N);
        check("R4 reset clears lock flag", chan_locked, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (QUAL) step();
        check("R4 timer cleared by reset", lane_state, ALL_N);
        step();
        check("R4 acquiring after full interval", lane_state, ALL_A);

        done = 1;
        summary();
        $finish;
    end
endmodule